// File: doc/BRIEF.md
# Fractional Pixel Clock Oscillator

This block is a phase-accumulating oscillator that paces a video streamer. On every system clock in which it is enabled, it adds a programmed increment to a 32-bit phase register. In pixel mode, each carry out of the top bit raises a one-clock advance strobe, so the pixel rate is the system clock scaled by the increment divided by 2^32.

A start-of-stream pulse returns the phase to zero. Because of this, the strobes fall on the same clock offsets on every scan line, and a fractional divide ratio shows no line-to-line jitter.

In table mode the strobe is held off. The upper eight phase bits are then presented as an address into an external 256-entry waveform table, which turns the block into a direct digital synthesizer front end.

Top module: `nco_pixel_strobe`

## Requirements
- R1: On each rising clock edge with `en` high and `restart` low, `phase` becomes the previous `phase` plus `freq_word`, modulo 2^32.
- R2: With `fn_mode` low, `pix_strobe` is high for the one clock that follows an edge at which the addition of R1 carried out of bit 31. At all other times it is low.
- R3: An edge with `restart` high sets `phase` to 0 and `pix_strobe` low, whatever the state of `en`. The first addition happens at the next edge.
- R4: With `freq_word` = 0x55555556, the first strobe follows the third enabled edge after a restart. Strobes then recur exactly every third clock for at least 10,000 clocks.
- R5: With `freq_word` = 0, `phase` holds its value and no strobe is produced.
- R6: With `freq_word` = 0x80000000, the first strobe follows the second enabled edge after a restart. Strobes then recur every second clock.
- R7: With `fn_mode` high, `tbl_index` equals `phase[31:24]` and `pix_strobe` stays low, including across a phase wrap. With `fn_mode` low, `tbl_index` is 0.
- R8: An edge with `en` low and `restart` low leaves `phase` unchanged (it is not cleared) and drives `pix_strobe` low.
- R9: While `rst_n` is low, `phase`, `pix_strobe` and `tbl_index` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advances the phase when high; freezes it when low |
| restart | input | 1 | Start-of-stream pulse that zeroes the phase |
| fn_mode | input | 1 | 1 = table index mode, 0 = pixel strobe mode |
| freq_word | input | 32 | Phase increment added on each enabled clock |
| pix_strobe | output | 1 | Registered one-clock pixel advance pulse |
| tbl_index | output | 8 | Waveform table address (phase bits 31:24 in table mode) |
| phase | output | 32 | Current accumulator value |

## Verification
The hardest condition to reach is long-run drift of a fractional ratio. A divide-by-three increment only leaves its three-clock pattern after billions of additions, and a wrong carry or width slip shows up only as a single displaced strobe. To expose it, the stimulus starts from a restart and compares every strobe position against the ideal period for more than 10,000 clocks. Table mode is driven with a small increment for a full 0-to-255 sweep that ends in a wrap, which confirms that the wrap advances the index but raises no strobe.

// File: rtl/nco_pixel_strobe.sv
module nco_pixel_strobe #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               restart,
  input  logic               fn_mode,
  input  logic [PHASE_W-1:0] freq_word,
  output logic               pix_strobe,
  output logic [IDX_W-1:0]   tbl_index,
  output logic [PHASE_W-1:0] phase
);

  logic [PHASE_W-1:0] acc_q;
  logic               stb_q;
  logic [PHASE_W:0]   sum_w;

  assign sum_w = {1'b0, acc_q} + {1'b0, freq_word};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      stb_q <= 1'b0;
    end else if (restart) begin
      acc_q <= '0;
      stb_q <= 1'b0;
    end else if (en) begin
      acc_q <= sum_w[PHASE_W-1:0];
      stb_q <= sum_w[PHASE_W] & ~fn_mode;
    end else begin
      stb_q <= 1'b0;
    end
  end

  assign phase      = acc_q;
  assign pix_strobe = stb_q;
  assign tbl_index  = fn_mode ? acc_q[PHASE_W-1 -: IDX_W] : '0;

endmodule

// File: rtl/nco_pixel_strobe_chk.sv
module nco_pixel_strobe_chk #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               restart,
  input logic               fn_mode,
  input logic [PHASE_W-1:0] freq_word,
  input logic               pix_strobe,
  input logic [IDX_W-1:0]   tbl_index,
  input logic [PHASE_W-1:0] phase
);

  AST_PHASE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart) |=> phase == $past(phase) + $past(freq_word)); // R1

  AST_STROBE_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !fn_mode) |=> pix_strobe == (phase < $past(phase))); // R2

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0) && !pix_strobe); // R3

  AST_ZERO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && freq_word == '0) |=> $stable(phase) && !pix_strobe); // R5

  AST_TABLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fn_mode |=> !pix_strobe); // R7

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> $stable(phase) && !pix_strobe); // R8

endmodule

bind nco_pixel_strobe nco_pixel_strobe_chk #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .fn_mode(fn_mode),
  .freq_word(freq_word), .pix_strobe(pix_strobe), .tbl_index(tbl_index), .phase(phase)
);

// File: tb/nco_pixel_strobe_tb_top.sv
module nco_pixel_strobe_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        restart = 1'b0;
  logic        fn_mode = 1'b0;
  logic [31:0] freq_word = '0;
  logic        pix_strobe;
  logic [7:0]  tbl_index;
  logic [31:0] phase;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nco_pixel_strobe dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .fn_mode(fn_mode),
    .freq_word(freq_word), .pix_strobe(pix_strobe), .tbl_index(tbl_index), .phase(phase)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_restart(input logic [31:0] f, input logic fm);
    freq_word = f; fn_mode = fm; en = 1'b1; restart = 1'b1;
    tick();
    restart = 1'b0;
  endtask

  task automatic t_reset();
    check(phase == 0, "R9 phase", phase, 0);
    check(pix_strobe == 0, "R9 strobe", pix_strobe, 0);
    check(tbl_index == 0, "R9 index", tbl_index, 0);
  endtask

  task automatic t_div3();
    int bad = 0;
    int first_i = -1;
    do_restart(32'h5555_5556, 1'b0);
    check(phase == 0, "R3 phase after restart", phase, 0);
    for (int i = 1; i <= 10002; i++) begin
      tick();
      if (pix_strobe != (i % 3 == 0)) begin
        bad++;
        if (first_i < 0) first_i = i;
      end
    end
    check(bad == 0, "R4 div3 spacing mismatches", bad, 0);
    if (first_i >= 0) $display("  first R4 mismatch at clock %0d", first_i);
  endtask

  task automatic t_div2();
    int bad = 0;
    do_restart(32'h8000_0000, 1'b0);
    for (int i = 1; i <= 40; i++) begin
      tick();
      if (pix_strobe != (i % 2 == 0)) bad++;
    end
    check(bad == 0, "R6 div2 spacing mismatches", bad, 0);
    check(tbl_index == 0, "R7 index zero in pixel mode", tbl_index, 0);
  endtask

  task automatic t_zero_word();
    int seen = 0;
    do_restart(32'h0000_0000, 1'b0);
    for (int i = 0; i < 50; i++) begin
      tick();
      if (pix_strobe) seen++;
    end
    check(seen == 0, "R5 strobes with zero word", seen, 0);
    check(phase == 0, "R5 phase holds", phase, 0);
  endtask

  task automatic t_freeze_and_priority();
    logic [31:0] held;
    int seen = 0;
    do_restart(32'h1234_5678, 1'b0);
    tick(); tick();
    check(phase == 32'h2468_ACF0, "R1 two adds", phase, 32'h2468_ACF0);
    en = 1'b0;
    held = phase;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (pix_strobe) seen++;
    end
    check(phase == held, "R8 frozen phase kept", phase, held);
    check(seen == 0, "R8 no strobe while frozen", seen, 0);
    en = 1'b1;
    tick();
    check(phase == held + 32'h1234_5678, "R8 resumes from held value", phase, held + 32'h1234_5678);
    freq_word = 32'hF000_0000;
    tick(); tick();
    check(pix_strobe == 1, "R2 strobe after carrying add", pix_strobe, 1);
    restart = 1'b1; en = 1'b1;
    tick();
    restart = 1'b0;
    check(phase == 0 && pix_strobe == 0, "R3 restart beats add", phase, 0);
    freq_word = 32'h0000_0100;
    tick();
    check(phase == 32'h0000_0100, "R3 first add after restart", phase, 32'h100);
    restart = 1'b1; en = 1'b0;
    tick();
    restart = 1'b0;
    check(phase == 0, "R3 restart while disabled", phase, 0);
  endtask

  task automatic t_table();
    int bad = 0;
    int stb = 0;
    do_restart(32'h0040_0000, 1'b1);
    for (int i = 1; i <= 1024; i++) begin
      tick();
      if (tbl_index != 8'((i >> 2) & 255)) bad++;
      if (pix_strobe) stb++;
    end
    check(bad == 0, "R7 index sweep mismatches", bad, 0);
    check(tbl_index == 0 && phase == 0, "R7 index wrapped to 0", tbl_index, 0);
    check(stb == 0, "R7 no strobe in table mode", stb, 0);
    fn_mode = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    check(phase == 0, "R9 idle after reset release", phase, 0);
    t_div3();
    t_div2();
    t_zero_word();
    t_freeze_and_priority();
    t_table();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule